// File: doc/BRIEF.md
# Chained Signed Matrix Product Engine

This block evaluates D = (A×B)×C for three square matrices of signed 8-bit integers, 16×16 by default. A host fills the three operand buffers through one shared write port. A two-bit select on that port picks the target buffer. Writing the last entry of buffer C starts the computation.

Two multiply-accumulate units run in turn. The first builds A×B at full precision in an internal intermediate buffer. The second multiplies that buffer by C. It writes each result, sign-extended to 56 bits, into a result memory.

When every element of D is stored, the block raises a completion strobe for one cycle. The host then reads D through a synchronous read port. All storage consists of inferred simple dual-port memories, each with one write port and one registered read port.

Top module: `chained_matmul`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, `done` is 0 and `rd_data` is all zeros.
- R2: A write with `wr_sel` = 2'b11 changes no buffer. Codes 2'b00, 2'b01 and 2'b10 select buffers A, B and C respectively.
- R3: A buffer entry is written only at a rising clock edge where `wr_en` is 1. Address and data are taken from that same edge, and values presented with `wr_en` at 0 have no effect.
- R4: Computation starts only on a write to buffer C at address 255 (all address bits 1). Writes to buffer C at other addresses, and writes to A or B at any address, do not start it.
- R5: Element (row r, column c) of A, B, C and D sits at address r·16 + c, so storage is row-major.
- R6: The word stored for D(r,c) equals the exact sum over j of T(r,j)·C(j,c), where T(r,j) is the exact sum over k of A(r,k)·B(k,j). T is held as 20-bit signed values. The final sum is 32-bit signed and is sign-extended to 56 bits.
- R7: When `rd_en` is 1 at a rising edge, the word at `rd_addr` appears on `rd_data` just after that edge. When `rd_en` is 0, `rd_data` holds its value.
- R8: After all 256 words of D are stored, `done` is 1 for exactly one clock cycle.
- R9: Operands of all −128 give −536870912 in every element of D. Operands of all 127 give 524386048 in every element of D.
- R10: A new write of C entry 255 after completion starts a fresh computation over the current buffer contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously by the host |
| wr_en | input | 1 | Operand write strobe |
| wr_sel | input | 2 | Target buffer: 00 A, 01 B, 10 C, 11 none |
| wr_addr | input | 8 | Operand write address, row-major |
| wr_data | input | 8 | Signed operand element |
| rd_en | input | 1 | Result read strobe |
| rd_addr | input | 8 | Result read address, row-major |
| rd_data | output | 56 | Sign-extended result word, registered |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions assume that the host does not write any operand buffer while a computation is running. If it did, a product could mix old and new operands, and a second trigger would be dropped rather than queued. They also assume that the dimension is a power of two, so that row and column indices concatenate into addresses. The stimulus loads buffers only before a trigger and after the completion strobe. It changes the read address only between read strobes, which keeps every run within these limits.

// File: rtl/mpe_pkg.sv
package mpe_pkg;

  typedef enum logic [1:0] {
    SEL_A    = 2'b00,
    SEL_B    = 2'b01,
    SEL_C    = 2'b10,
    SEL_NONE = 2'b11
  } buf_sel_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_MUL1,
    PH_DRAIN1,
    PH_MUL2,
    PH_DRAIN2,
    PH_DONE
  } phase_e;

endpackage

// File: rtl/mpe_sdp_ram.sv
module mpe_sdp_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_n;

  // storage array: write port, no reset
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata_n = rdata;
    if (re) begin
      rdata_n = mem[raddr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else begin
      rdata <= rdata_n;
    end
  end

  // R7: output register holds while no read is requested
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata));

endmodule

// File: rtl/mpe_mac.sv
module mpe_mac #(
  parameter int A_W  = 8,
  parameter int B_W  = 8,
  parameter int ACCW = 20,
  localparam int PW  = A_W + B_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_vld,
  input  logic                   first,
  input  logic                   last,
  input  logic signed [A_W-1:0]  a,
  input  logic signed [B_W-1:0]  b,
  output logic signed [ACCW-1:0] acc,
  output logic                   res_vld
);

  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] prod_ext;
  logic signed [ACCW-1:0] acc_n;
  logic                   res_vld_n;

  assign prod     = a * b;
  assign prod_ext = ACCW'(prod);

  always_comb begin
    acc_n     = acc;
    res_vld_n = in_vld && last;
    if (in_vld) begin
      if (first) begin
        acc_n = prod_ext;
      end else begin
        acc_n = acc + prod_ext;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      res_vld <= 1'b0;
    end else begin
      acc     <= acc_n;
      res_vld <= res_vld_n;
    end
  end

endmodule

// File: rtl/mpe_ctrl.sv
module mpe_ctrl
  import mpe_pkg::*;
#(
  parameter int DIM       = 16,
  parameter int DRAIN_CYC = 3,
  localparam int IW       = $clog2(DIM),
  localparam int AW       = 2 * IW,
  localparam int DRW      = $clog2(DRAIN_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          iss_s1,
  output logic          iss_s2,
  output logic [AW-1:0] row_addr,
  output logic [AW-1:0] col_addr,
  output logic          mac1_vld,
  output logic          mac2_vld,
  output logic          mac_first,
  output logic          mac_last,
  output logic [AW-1:0] wr_addr
);

  localparam logic [IW-1:0]  LAST_IDX  = IW'(DIM - 1);
  localparam logic [DRW-1:0] LAST_DRN  = DRW'(DRAIN_CYC - 1);

  phase_e          phase_q, phase_n;
  logic [IW-1:0]   cr_q, cr_n, cc_q, cc_n, ck_q, ck_n;
  logic [DRW-1:0]  drn_q, drn_n;
  logic            v1_q, v1_n, s2_q, s2_n, f1_q, f1_n, l1_q, l1_n;
  logic [AW-1:0]   ea1_q, ea1_n, ea2_q, ea2_n;
  logic            issuing;

  assign issuing = (phase_q == PH_MUL1) || (phase_q == PH_MUL2);

  // next-state: phase and index counters
  always_comb begin
    phase_n = phase_q;
    cr_n    = cr_q;
    cc_n    = cc_q;
    ck_n    = ck_q;
    drn_n   = drn_q;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_n = PH_MUL1;
          cr_n    = '0;
          cc_n    = '0;
          ck_n    = '0;
        end
      end
      PH_MUL1, PH_MUL2: begin
        ck_n = ck_q + 1'b1;
        if (ck_q == LAST_IDX) begin
          cc_n = cc_q + 1'b1;
          if (cc_q == LAST_IDX) begin
            cr_n = cr_q + 1'b1;
            if (cr_q == LAST_IDX) begin
              phase_n = (phase_q == PH_MUL1) ? PH_DRAIN1 : PH_DRAIN2;
              drn_n   = '0;
            end
          end
        end
      end
      PH_DRAIN1, PH_DRAIN2: begin
        drn_n = drn_q + 1'b1;
        if (drn_q == LAST_DRN) begin
          phase_n = (phase_q == PH_DRAIN1) ? PH_MUL2 : PH_DONE;
        end
      end
      PH_DONE: phase_n = PH_IDLE;
      default: phase_n = PH_IDLE;
    endcase
  end

  // next-state: pipeline alongside the memory read and the MAC
  always_comb begin
    v1_n  = issuing;
    s2_n  = (phase_q == PH_MUL2);
    f1_n  = (ck_q == '0);
    l1_n  = (ck_q == LAST_IDX);
    ea1_n = {cr_q, cc_q};
    ea2_n = ea1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cr_q    <= '0;
      cc_q    <= '0;
      ck_q    <= '0;
      drn_q   <= '0;
      v1_q    <= 1'b0;
      s2_q    <= 1'b0;
      f1_q    <= 1'b0;
      l1_q    <= 1'b0;
      ea1_q   <= '0;
      ea2_q   <= '0;
    end else begin
      phase_q <= phase_n;
      cr_q    <= cr_n;
      cc_q    <= cc_n;
      ck_q    <= ck_n;
      drn_q   <= drn_n;
      v1_q    <= v1_n;
      s2_q    <= s2_n;
      f1_q    <= f1_n;
      l1_q    <= l1_n;
      ea1_q   <= ea1_n;
      ea2_q   <= ea2_n;
    end
  end

  assign busy      = (phase_q != PH_IDLE);
  assign done      = (phase_q == PH_DONE);
  assign iss_s1    = (phase_q == PH_MUL1);
  assign iss_s2    = (phase_q == PH_MUL2);
  assign row_addr  = {cr_q, ck_q};
  assign col_addr  = {ck_q, cc_q};
  assign mac1_vld  = v1_q && !s2_q;
  assign mac2_vld  = v1_q && s2_q;
  assign mac_first = f1_q;
  assign mac_last  = l1_q;
  assign wr_addr   = ea2_q;

  // R8: the completion strobe never lasts two cycles
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/chained_matmul.sv
module chained_matmul
  import mpe_pkg::*;
#(
  parameter int DIM  = 16,
  parameter int EW   = 8,
  parameter int OW   = 56,
  localparam int AW  = $clog2(DIM * DIM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_addr,
  input  logic [EW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [OW-1:0] rd_data,
  output logic          done
);

  localparam int CELLS = DIM * DIM;
  localparam int KW    = $clog2(DIM);
  localparam int IW    = 2 * EW + KW;
  localparam int FW    = IW + EW + KW;
  localparam int NBUF  = 3;

  logic          start_req;
  logic          busy, iss_s1, iss_s2;
  logic [AW-1:0] row_addr, col_addr, res_addr;
  logic          mac1_vld, mac2_vld, mac_first, mac_last;
  logic [EW-1:0] in_q [NBUF];
  logic [IW-1:0] t_q;
  logic signed [IW-1:0] acc1;
  logic signed [FW-1:0] acc2;
  logic          t_we, d_we;

  assign start_req = wr_en && (buf_sel_e'(wr_sel) == SEL_C) && (wr_addr == {AW{1'b1}});

  mpe_ctrl #(.DIM(DIM)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_req),
    .busy      (busy),
    .done      (done),
    .iss_s1    (iss_s1),
    .iss_s2    (iss_s2),
    .row_addr  (row_addr),
    .col_addr  (col_addr),
    .mac1_vld  (mac1_vld),
    .mac2_vld  (mac2_vld),
    .mac_first (mac_first),
    .mac_last  (mac_last),
    .wr_addr   (res_addr)
  );

  // operand buffers A, B, C: A is walked along a row, B and C down a column
  for (genvar gi = 0; gi < NBUF; gi++) begin : g_inbuf
    localparam logic [1:0] MY_SEL = 2'(gi);
    logic          b_we, b_re;
    logic [AW-1:0] b_raddr;
    assign b_we    = wr_en && (wr_sel == MY_SEL);
    assign b_re    = (gi == 2) ? iss_s2 : iss_s1;
    assign b_raddr = (gi == 0) ? row_addr : col_addr;
    mpe_sdp_ram #(.DW(EW), .DEPTH(CELLS)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (b_we),
      .waddr (wr_addr),
      .wdata (wr_data),
      .re    (b_re),
      .raddr (b_raddr),
      .rdata (in_q[gi])
    );
  end

  mpe_mac #(.A_W(EW), .B_W(EW), .ACCW(IW)) u_mac1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (mac1_vld),
    .first   (mac_first),
    .last    (mac_last),
    .a       (in_q[0]),
    .b       (in_q[1]),
    .acc     (acc1),
    .res_vld (t_we)
  );

  mpe_sdp_ram #(.DW(IW), .DEPTH(CELLS)) u_tmp (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (t_we),
    .waddr (res_addr),
    .wdata (acc1),
    .re    (iss_s2),
    .raddr (row_addr),
    .rdata (t_q)
  );

  mpe_mac #(.A_W(IW), .B_W(EW), .ACCW(FW)) u_mac2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (mac2_vld),
    .first   (mac_first),
    .last    (mac_last),
    .a       (t_q),
    .b       (in_q[2]),
    .acc     (acc2),
    .res_vld (d_we)
  );

  mpe_sdp_ram #(.DW(OW), .DEPTH(CELLS)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (d_we),
    .waddr (res_addr),
    .wdata (OW'(acc2)),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // R4: a run begins only on the cycle after the last C entry is written
  a_r4_start_on_c_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && wr_sel == 2'b10 && wr_addr == {AW{1'b1}}));

  // R6: the two stages never write their buffers in the same cycle
  a_r6_stage_writes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(t_we && d_we));

endmodule

// File: tb/chained_matmul_tb.sv
module chained_matmul_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DIM        = 16;
  localparam int CELLS      = DIM * DIM;
  localparam int N_CASES    = 4;
  localparam int WATCHDOG   = 150000;
  localparam int DONE_LIMIT = 20000;
  // case table: operand pattern kind and generator seed
  // kind 0 random, 1 all -128, 2 all 127, 3 random mixed with extremes
  localparam int          KIND [N_CASES] = '{0, 1, 2, 3};
  localparam int unsigned SEED [N_CASES] = '{32'h1234_5678, 32'h0, 32'h0, 32'hCAFE_0101};

  logic        clk, rst_n, wr_en, rd_en, done;
  logic [1:0]  wr_sel;
  logic [7:0]  wr_addr, wr_data, rd_addr;
  logic [55:0] rd_data;

  int errors, checks;
  int ma [CELLS];
  int mb [CELLS];
  int mc [CELLS];
  longint md [CELLS];

  chained_matmul u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gen(input int kind, inout int unsigned st);
    int v;
    st = st * 32'd1103515245 + 32'd12345;
    v  = int'($signed(st[23:16]));
    case (kind)
      1: return -128;
      2: return 127;
      3: begin
        if (st[5:4] == 2'd0) return -128;
        if (st[5:4] == 2'd1) return 127;
        return v;
      end
      default: return v;
    endcase
  endfunction

  task automatic wr(input logic [1:0] sel, input int addr, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_addr = 8'(addr);
    wr_data = 8'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic rd(input int addr, output longint v);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = 8'(addr);
    @(negedge clk);
    rd_en   = 1'b0;
    v = longint'($signed(rd_data));
  endtask

  task automatic model();
    longint t [CELLS];
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++) begin
        longint s = 0;
        for (int k = 0; k < DIM; k++) s += longint'(ma[r*DIM+k]) * mb[k*DIM+c];
        t[r*DIM+c] = s;
      end
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++) begin
        longint s = 0;
        for (int k = 0; k < DIM; k++) s += t[r*DIM+k] * mc[k*DIM+c];
        md[r*DIM+c] = s;
      end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    errors = 0;
    checks = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'b00; wr_addr = '0; wr_data = '0;
    rd_en = 1'b0; rd_addr = '0;
    repeat (10) @(negedge clk);
    check(done == 1'b0, "R1 done during reset", longint'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", longint'(done), 0);
    check(rd_data == '0, "R1 rd_data after reset", longint'(rd_data), 0);

    for (int ci = 0; ci < N_CASES; ci++) begin
      int unsigned st = SEED[ci];
      int     cyc, mism, seen;
      longint v, hold;
      string  req;
      for (int i = 0; i < CELLS; i++) ma[i] = gen(KIND[ci], st);
      for (int i = 0; i < CELLS; i++) mb[i] = gen(KIND[ci], st);
      for (int i = 0; i < CELLS; i++) mc[i] = gen(KIND[ci], st);
      model();
      for (int i = 0; i < CELLS; i++) wr(2'b00, i, ma[i]);
      for (int i = 0; i < CELLS; i++) wr(2'b01, i, mb[i]);
      for (int i = 0; i < CELLS - 1; i++) wr(2'b10, i, mc[i]);
      // R3: values presented with wr_en low must be ignored
      @(negedge clk);
      wr_sel = 2'b00; wr_addr = 8'd0; wr_data = ~8'(ma[0]);
      @(negedge clk);
      wr_sel = 2'b10; wr_addr = 8'd255; wr_data = ~8'(mc[255]);
      // R2: select 11 must touch no buffer
      wr(2'b11, 0, 8'h5A);
      wr(2'b11, 255, 8'hA5);
      if (ci == 0) begin
        // R4: nothing starts until C entry 255 is written
        seen = 0;
        for (int w = 0; w < 9000; w++) begin
          @(negedge clk);
          if (done) seen++;
        end
        check(seen == 0, "R4 done before C[255] write", seen, 0);
      end
      wr(2'b10, CELLS - 1, mc[CELLS - 1]);
      cyc = 0;
      while (!done && cyc < DONE_LIMIT) begin
        @(negedge clk);
        cyc++;
      end
      req = (ci == 0) ? "R8 done strobe" : "R10 rerun done strobe";
      check(done == 1'b1, req, longint'(done), 1);
      @(negedge clk);
      check(done == 1'b0, "R8 done one cycle", longint'(done), 0);
      mism = 0;
      for (int i = 0; i < CELLS; i++) begin
        rd(i, v);
        if (v != md[i]) mism++;
        // R5 row-major address, R6 value
        check(v == md[i], (ci == 0) ? "R6 D element" : "R10 D element", v, md[i]);
      end
      check(mism == 0, "R2 R3 ignored writes left buffers intact", mism, 0);
      if (KIND[ci] == 1) begin
        rd(17, v);
        check(v == -64'sd536870912, "R9 all -128", v, -64'sd536870912);
      end
      if (KIND[ci] == 2) begin
        rd(200, v);
        check(v == 64'sd524386048, "R9 all 127", v, 64'sd524386048);
      end
      // R7: output holds while rd_en is low
      rd(5, hold);
      @(negedge clk);
      rd_addr = 8'd9;
      @(negedge clk);
      v = longint'($signed(rd_data));
      check(v == hold, "R7 hold without rd_en", v, hold);
      check(hold == md[5], "R7 read after edge", hold, md[5]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule